// File: doc/BRIEF.md
# Systolic Local-Alignment Score Engine

This block scores a short DNA query against a streamed database sequence with the local-alignment dynamic-programming recurrence, and reports the highest cell value in the whole scoring matrix. It is a linear chain of processing elements. Each element keeps one query character for the length of a run. Database characters enter element 0 at one per clock and move one element along the chain on each clock. Every element therefore fills one matrix cell per step, and all cells on one anti-diagonal are computed in the same cycle.

Software loads the query one character at a time through a small write port. It then pulses `start` with the query length on `qry_len`. The start pulse clears every cell, every running maximum and the completion flag. After that the database is streamed with a valid flag and a last flag. Each element keeps a running maximum and passes it down the chain together with the data, so the final element holds the global best. `done` rises a fixed number of cycles after the last character is accepted and stays high until the next start.

Top module: `sw_systolic_array`

## Requirements
- R1: A write with `qry_we` high stores `qry_chr` as the query character of the element selected by `qry_idx`. Element 0 aligns against the first query position. Characters are 2-bit codes: A=00, C=01, G=10, T=11.
- R2: Each cell takes the largest of four values: 0, the diagonal neighbour plus 2 when the query and database characters are equal (minus 1 when they differ), the upper neighbour minus 1, and the left neighbour minus 1. Cells on the matrix border count as 0.
- R3: After `done` rises, `best` equals the largest cell value anywhere in the qry_len × N matrix.
- R4: A stream slot with `db_valid` low updates no cell, whatever its character, so the result is the same as for the stream without that slot.
- R5: `done` rises exactly NPE clock edges after the edge that accepts the character flagged `db_last`. It then stays high until the next `start`.
- R6: The cycle after `start`, `best` reads 0 and `done` reads 0, whatever the previous run left behind.
- R7: Elements at or beyond the `qry_len` captured at `start` never contribute to `best`, whatever characters they hold.
- R8: After reset, `best` is 0 and `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| qry_we | input | 1 | Query character write strobe |
| qry_idx | input | IW | Element index for the query write |
| qry_chr | input | 2 | Query character code |
| qry_len | input | LW | Number of active elements, captured on start |
| start | input | 1 | Clears cells, maxima and done; begins a run |
| db_valid | input | 1 | Database slot carries a character |
| db_last | input | 1 | Marks the final database character |
| db_chr | input | 2 | Database character code |
| best | output | SW | Best local-alignment score so far |
| done | output | 1 | Final character has left the last element |

## Verification
The bench builds the array with NPE=4 and 16-bit scores. At that size the bench can sweep all 256 four-character queries, and all 64 three-character databases at two query lengths, in a short run. Each sweep is compared with a full matrix computed in the bench. Padded runs load characters that would match into the unused elements, which shows they add nothing. Random runs place bubbles carrying random characters between valid slots. Every run also checks the exact cycle on which `done` rises.

// File: rtl/sw_systolic_array.sv
module sw_systolic_array #(
  parameter int NPE = 16,
  parameter int SW  = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      qry_we,
  input  logic [((NPE>1)?$clog2(NPE):1)-1:0] qry_idx,
  input  logic [1:0]                qry_chr,
  input  logic [$clog2(NPE+1)-1:0]  qry_len,
  input  logic                      start,
  input  logic                      db_valid,
  input  logic                      db_last,
  input  logic [1:0]                db_chr,
  output logic [SW-1:0]             best,
  output logic                      done
);
  localparam int IW = (NPE > 1) ? $clog2(NPE) : 1;
  localparam int LW = $clog2(NPE + 1);
  localparam logic [SW-1:0] SMAX = {SW{1'b1}};

  function automatic logic [SW-1:0] dec1(input logic [SW-1:0] x);
    return (x == '0) ? '0 : x - 1'b1;
  endfunction

  function automatic logic [SW-1:0] inc2(input logic [SW-1:0] x);
    return (x > SMAX - 2) ? SMAX : x + 2;
  endfunction

  function automatic logic [SW-1:0] max2(input logic [SW-1:0] a, input logic [SW-1:0] b);
    return (a > b) ? a : b;
  endfunction

  logic [NPE-1:0][1:0]    qc;
  logic [LW-1:0]          len;
  logic [NPE-1:0][1:0]    dc;
  logic [NPE-1:0]         dv, dl;
  logic [NPE-1:0][SW-1:0] h, hd, mx, hn;
  logic [NPE-1:0][1:0]    ic;
  logic [NPE-1:0]         iv, il;
  logic [NPE-1:0][SW-1:0] up, dg, mi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qc  <= '0;
      len <= '0;
    end else begin
      if (qry_we) qc[qry_idx] <= qry_chr;
      if (start) len <= qry_len;
    end
  end

  generate
    for (genvar g = 0; g < NPE; g++) begin : g_pe
      if (g == 0) begin : g_head
        assign ic[g] = db_chr;
        assign iv[g] = db_valid;
        assign il[g] = db_last;
        assign up[g] = '0;
        assign dg[g] = '0;
        assign mi[g] = '0;
      end else begin : g_link
        assign ic[g] = dc[g-1];
        assign iv[g] = dv[g-1];
        assign il[g] = dl[g-1];
        assign up[g] = h[g-1];
        assign dg[g] = hd[g-1];
        assign mi[g] = mx[g-1];
      end

      logic          act;
      logic [SW-1:0] sd;
      assign act   = (g < int'(len));
      assign sd    = (qc[g] == ic[g]) ? inc2(dg[g]) : dec1(dg[g]);
      assign hn[g] = act ? max2(sd, max2(dec1(up[g]), dec1(h[g]))) : '0;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          h[g]  <= '0;
          hd[g] <= '0;
          mx[g] <= '0;
          dc[g] <= '0;
          dv[g] <= 1'b0;
          dl[g] <= 1'b0;
        end else if (start) begin
          h[g]  <= '0;
          hd[g] <= '0;
          mx[g] <= '0;
          dc[g] <= '0;
          dv[g] <= 1'b0;
          dl[g] <= 1'b0;
        end else begin
          dc[g] <= ic[g];
          dv[g] <= iv[g];
          dl[g] <= il[g];
          if (iv[g]) begin
            hd[g] <= h[g];
            h[g]  <= hn[g];
          end
          mx[g] <= max2(mx[g], max2(mi[g], iv[g] ? hn[g] : '0));
        end
      end

      AST_PAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (g >= int'(len)) |-> (h[g] == '0)); // R7
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       done <= 1'b0;
    else if (start)                   done <= 1'b0;
    else if (dv[NPE-1] && dl[NPE-1])  done <= 1'b1;
  end

  assign best = mx[NPE-1];

  AST_START_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (best == '0 && !done)); // R6
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done); // R5
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(dv[NPE-1] && dl[NPE-1])); // R5
  AST_BUBBLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !db_valid) |=> $stable(h[0])); // R4
  AST_SCORE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ((SW+LW+1)'(best) <= (SW+LW+1)'(len) * 2)); // R2
endmodule

// File: tb/sw_systolic_array_test.sv
module sw_systolic_array_test;
  localparam int NPE = 4;
  localparam int SW  = 16;

  logic clk = 0, rst_n = 0;
  logic qry_we = 0, start = 0, db_valid = 0, db_last = 0;
  logic [1:0] qry_idx = 0, qry_chr = 0, db_chr = 0;
  logic [2:0] qry_len = 0;
  logic [SW-1:0] best;
  logic done;

  int total = 0, bad = 0, cyc = 0;
  int qs [0:3];
  int dbs [0:15];

  always #2 clk = ~clk;

  sw_systolic_array #(.NPE(NPE), .SW(SW)) uut (
    .clk(clk), .rst_n(rst_n), .qry_we(qry_we), .qry_idx(qry_idx), .qry_chr(qry_chr),
    .qry_len(qry_len), .start(start), .db_valid(db_valid), .db_last(db_last),
    .db_chr(db_chr), .best(best), .done(done));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog: act=%0d exp=<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int ref_best(int ql, int n);
    int hm [0:4][0:16];
    int b = 0;
    for (int i = 0; i <= 4; i++) for (int j = 0; j <= 16; j++) hm[i][j] = 0;
    for (int i = 1; i <= ql; i++)
      for (int j = 1; j <= n; j++) begin
        int v = 0;
        int d = hm[i-1][j-1] + ((qs[i-1] == dbs[j-1]) ? 2 : -1);
        if (d > v) v = d;
        if (hm[i-1][j] - 1 > v) v = hm[i-1][j] - 1;
        if (hm[i][j-1] - 1 > v) v = hm[i][j-1] - 1;
        hm[i][j] = v;
        if (v > b) b = v;
      end
    return b;
  endfunction

  task automatic run(input int ql, input int n, input bit bub, input string tag);
    int exp, tmiss;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); qry_we = 1; qry_idx = 2'(k); qry_chr = 2'(qs[k]);
    end
    @(negedge clk); qry_we = 0; qry_len = 3'(ql); start = 1;
    @(negedge clk); start = 0;
    check(best == 0 && done == 0, "R6 start clear", int'(best) + int'(done), 0);
    for (int j = 0; j < n; j++) begin
      if (bub && ($urandom % 3 == 0)) begin
        db_valid = 0; db_last = 1'($urandom); db_chr = 2'($urandom);
        @(negedge clk);
      end
      db_valid = 1; db_chr = 2'(dbs[j]); db_last = (j == n - 1);
      @(negedge clk);
    end
    db_valid = 0; db_last = 0;
    tmiss = (done != 0);
    for (int k = 1; k <= NPE; k++) begin
      @(negedge clk);
      if (done != (k == NPE)) tmiss++;
    end
    check(tmiss == 0, "R5 done timing", tmiss, 0);
    exp = ref_best(ql, n);
    check(int'(best) == exp, tag, int'(best), exp);
  endtask

  initial begin
    #1;
    check(best == 0 && done == 0, "R8 reset state", int'(best) + int'(done), 0);
    @(negedge clk); rst_n = 1;

    for (int q = 0; q < 256; q++) begin
      for (int k = 0; k < 4; k++) qs[k] = (q >> (2 * k)) & 3;
      for (int j = 0; j < 10; j++) dbs[j] = (q * 5 + j * 3 + j * j) % 4;
      run(4, 10, 0, "R1 R2 R3 query sweep");
    end

    for (int pass = 0; pass < 2; pass++)
      for (int d = 0; d < 64; d++) begin
        for (int j = 0; j < 3; j++) dbs[j] = (d >> (2 * j)) & 3;
        qs[0] = 2; qs[1] = 0;
        if (pass == 0) begin qs[2] = 3; qs[3] = 1; end
        else begin qs[2] = dbs[0]; qs[3] = dbs[1]; end
        run(pass == 0 ? 4 : 2, 3, 0, pass == 0 ? "R2 R3 db sweep" : "R7 padded sweep");
      end

    for (int r = 0; r < 40; r++) begin
      int n = 1 + ($urandom % 16);
      for (int k = 0; k < 4; k++) qs[k] = $urandom % 4;
      for (int j = 0; j < n; j++) dbs[j] = $urandom % 4;
      run(1 + (r % 4), n, 1, "R4 bubbles");
    end

    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    check(best == 0 && done == 0, "R6 final clear", int'(best) + int'(done), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule